// File: doc/BRIEF.md
# Cascadable presettable up/down counter

This block is a synchronous binary counter built from 4-bit stages. Each stage counts up or down, holds, or takes a parallel preset, and every state bit updates on the same rising clock edge. Two active-low count enables gate counting, a "parallel" enable and a "trickle" enable. An active-low load forces a preset of the whole register from the data input at the next edge. A direction input picks increment (high) or decrement (low).

Each stage drives an active-low carry. The carry is decoded from that stage's count, the direction and the trickle enable. It goes low only while the trickle enable is low and the stage sits at its terminal value: all ones when counting up, zero when counting down. The top module chains a parameterised number of stages. Each stage's carry feeds the next stage's trickle enable, and all stages share the clock, the parallel enable, the load and the direction. The chain therefore acts as one wide synchronous up/down counter, and its final carry is available for further cascading.

Each stage decodes its inputs into one of four operating states every cycle: MODE_LOAD (load low), MODE_HOLD (load high and either enable high), MODE_UP (both enables low, direction high) and MODE_DOWN (both enables low, direction low). The state is re-chosen at every clock edge from the inputs sampled there. Any state can follow any other. Load has priority over counting.

Top module: `updn_chain`

## Requirements
- R1: While rst_n is low at a rising edge, q becomes all zeros at that edge.
- R2: With load_n high and both en_p_n and en_t_n low, q increments by one at each rising edge when up is 1 and decrements by one when up is 0.
- R3: With load_n high and either en_p_n or en_t_n high, q keeps its value across the edge.
- R4: With load_n low, q takes din at the next rising edge, whatever the enables and direction are.
- R5: Counting wraps modulo 2^(4*STAGES): all ones plus one gives zero, and zero minus one gives all ones.
- R6: carry_n is 0 exactly when en_t_n is 0 and either up is 1 with q all ones, or up is 0 with q zero. It follows changes of up and en_t_n with no clock edge.
- R7: In the chain, a stage above the lowest one changes during counting only when all lower stages are at their terminal value for the current direction. A one-stage instance (STAGES=1) behaves as a plain 4-bit counter.
- R8: Reversing the direction while the count is at a terminal value takes effect at the next edge. Up at all ones followed by a switch to down gives all ones minus one, and down at zero followed by a switch to up gives one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all stages |
| rst_n | input | 1 | Synchronous active-low reset to zero |
| en_p_n | input | 1 | Parallel count enable, active low, shared by all stages |
| en_t_n | input | 1 | Trickle count enable of the lowest stage, active low, gates the carry |
| load_n | input | 1 | Synchronous preset, active low |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | 4*STAGES | Preset value |
| q | output | 4*STAGES | Current count |
| carry_n | output | 1 | Active-low carry of the top stage |

## Verification
The assertions check on every cycle the reset value, load, hold, increment and decrement with wrap across the full width, and the carry decode. They also check that upper stages stay put while the lower stage is not at its terminal value. Only the bench's scenarios can show that carry_n reacts to up and en_t_n between edges, that reversing direction exactly at terminal count works, and that a one-stage instance tracks a 4-bit model. The bench also runs a long random stream of enables, loads and direction flips and compares the chain against a model cycle by cycle.

// File: rtl/updn_pkg.sv
package updn_pkg;

    localparam int unsigned STAGE_BITS = 4;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'd0,
        MODE_LOAD = 2'd1,
        MODE_UP   = 2'd2,
        MODE_DOWN = 2'd3
    } mode_e;

endpackage

// File: rtl/updn_mode_dec.sv
module updn_mode_dec
    import updn_pkg::*;
(
    input  logic  en_p_n,
    input  logic  en_t_n,
    input  logic  load_n,
    input  logic  up,
    output mode_e mode
);

    logic count_ok;

    always_comb begin
        count_ok = !en_p_n && !en_t_n;
        if (!load_n) begin
            mode = MODE_LOAD;
        end else if (!count_ok) begin
            mode = MODE_HOLD;
        end else if (up) begin
            mode = MODE_UP;
        end else begin
            mode = MODE_DOWN;
        end
    end

endmodule

// File: rtl/updn_cell.sv
module updn_cell
    import updn_pkg::*;
#(
    parameter int unsigned W = STAGE_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mode_e        mode,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] q_next;

    always_comb begin
        unique case (mode)
            MODE_LOAD: q_next = din;
            MODE_UP:   q_next = q + ONE;
            MODE_DOWN: q_next = q - ONE;
            MODE_HOLD: q_next = q;
            default:   q_next = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/updn_carry.sv
module updn_carry #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] q,
    input  logic         up,
    input  logic         en_t_n,
    output logic         carry_n
);

    logic at_max;
    logic at_min;
    logic terminal;

    always_comb begin
        at_max   = &q;
        at_min   = ~|q;
        terminal = up ? at_max : at_min;
        carry_n  = !(terminal && !en_t_n);
    end

endmodule

// File: rtl/updn_stage.sv
module updn_stage
    import updn_pkg::*;
#(
    parameter int unsigned W = STAGE_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_p_n,
    input  logic         en_t_n,
    input  logic         load_n,
    input  logic         up,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         carry_n
);

    mode_e mode;

    updn_mode_dec u_dec (
        .en_p_n (en_p_n),
        .en_t_n (en_t_n),
        .load_n (load_n),
        .up     (up),
        .mode   (mode)
    );

    updn_cell #(.W(W)) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .din   (din),
        .q     (q)
    );

    updn_carry #(.W(W)) u_carry (
        .q       (q),
        .up      (up),
        .en_t_n  (en_t_n),
        .carry_n (carry_n)
    );

endmodule

// File: rtl/updn_chain.sv
module updn_chain
    import updn_pkg::*;
#(
    parameter int unsigned STAGES  = 3,
    parameter int unsigned STAGE_W = STAGE_BITS,
    localparam int unsigned TOTAL_W = STAGES * STAGE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_p_n,
    input  logic               en_t_n,
    input  logic               load_n,
    input  logic               up,
    input  logic [TOTAL_W-1:0] din,
    output logic [TOTAL_W-1:0] q,
    output logic               carry_n
);

    logic [STAGES:0] t_link;

    assign t_link[0] = en_t_n;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        updn_stage #(.W(STAGE_W)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_p_n  (en_p_n),
            .en_t_n  (t_link[k]),
            .load_n  (load_n),
            .up      (up),
            .din     (din[k*STAGE_W +: STAGE_W]),
            .q       (q[k*STAGE_W +: STAGE_W]),
            .carry_n (t_link[k+1])
        );
    end

    assign carry_n = t_link[STAGES];

endmodule

// File: rtl/updn_chain_chk.sv
module updn_chain_chk #(
    parameter int unsigned STAGES  = 3,
    parameter int unsigned STAGE_W = 4,
    localparam int unsigned TOTAL_W = STAGES * STAGE_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en_p_n,
    input logic               en_t_n,
    input logic               load_n,
    input logic               up,
    input logic [TOTAL_W-1:0] din,
    input logic [TOTAL_W-1:0] q,
    input logic               carry_n
);

    localparam logic [TOTAL_W-1:0] ONE = TOTAL_W'(1);

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !en_p_n && !en_t_n && up) |=> (q == $past(q) + ONE));

    p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !en_p_n && !en_t_n && !up) |=> (q == $past(q) - ONE));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && (en_p_n || en_t_n)) |=> $stable(q));

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (q == $past(din)));

    p_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        carry_n == !(!en_t_n && (up ? (&q) : (q == '0))));

    if (STAGES > 1) begin : g_chain
        p_upper_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (load_n && !en_p_n && !en_t_n &&
             (up ? (q[STAGE_W-1:0] != '1) : (q[STAGE_W-1:0] != '0)))
            |=> $stable(q[TOTAL_W-1:STAGE_W]));
    end

endmodule

bind updn_chain updn_chain_chk #(.STAGES(STAGES), .STAGE_W(STAGE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_p_n  (en_p_n),
    .en_t_n  (en_t_n),
    .load_n  (load_n),
    .up      (up),
    .din     (din),
    .q       (q),
    .carry_n (carry_n)
);

// File: tb/updn_chain_tb.sv
module updn_chain_tb;

    localparam int W  = 12;
    localparam int W1 = 4;

    typedef struct packed {
        logic          ld_n;
        logic          p_n;
        logic          t_n;
        logic          up;
        logic [W-1:0]  din;
        logic [W-1:0]  exp_q;
        logic          exp_c;
    } vec_t;

    // Rows applied in order starting from q = 0 after reset.
    localparam vec_t TABLE [15] = '{
        '{1'b0, 1'b1, 1'b1, 1'b1, 12'hFFE, 12'hFFE, 1'b1}, // R4 load with enables off
        '{1'b1, 1'b0, 1'b0, 1'b1, 12'h000, 12'hFFF, 1'b0}, // R2 up, R6 carry at max
        '{1'b1, 1'b0, 1'b0, 1'b1, 12'h000, 12'h000, 1'b1}, // R5 wrap up
        '{1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 12'hFFF, 1'b1}, // R5 wrap down
        '{1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 12'hFFE, 1'b1}, // R2 down
        '{1'b1, 1'b1, 1'b0, 1'b0, 12'h123, 12'hFFE, 1'b1}, // R3 P high
        '{1'b1, 1'b0, 1'b1, 1'b0, 12'h123, 12'hFFE, 1'b1}, // R3 T high
        '{1'b0, 1'b0, 1'b0, 1'b1, 12'h001, 12'h001, 1'b1}, // R4 priority
        '{1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 12'h000, 1'b0}, // R6 carry at min
        '{1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 12'hFFF, 1'b1}, // R5
        '{1'b0, 1'b1, 1'b1, 1'b1, 12'h0FF, 12'h0FF, 1'b1}, // R4
        '{1'b1, 1'b0, 1'b0, 1'b1, 12'h000, 12'h100, 1'b1}, // R7 carry across stages
        '{1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 12'h0FF, 1'b1}, // R7 borrow across stages
        '{1'b0, 1'b0, 1'b0, 1'b1, 12'hF0F, 12'hF0F, 1'b1}, // R4
        '{1'b1, 1'b0, 1'b0, 1'b1, 12'h000, 12'hF10, 1'b1}  // R7
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en_p_n;
    logic          en_t_n;
    logic          load_n;
    logic          up;
    logic [W-1:0]  din;
    logic [W-1:0]  q;
    logic          carry_n;
    logic [W1-1:0] q1;
    logic          carry1_n;

    int n_tests = 0;
    int n_fail  = 0;
    logic [W-1:0]  mq;
    logic [W1-1:0] mq1;

    always #10 clk = ~clk;

    updn_chain #(.STAGES(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_p_n(en_p_n), .en_t_n(en_t_n),
        .load_n(load_n), .up(up), .din(din), .q(q), .carry_n(carry_n)
    );

    updn_chain #(.STAGES(1)) u_single (
        .clk(clk), .rst_n(rst_n), .en_p_n(en_p_n), .en_t_n(en_t_n),
        .load_n(load_n), .up(up), .din(din[W1-1:0]), .q(q1), .carry_n(carry1_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_carry(input logic [W-1:0] v, input int bits);
        logic [W-1:0] mask;
        mask = (W'(1) << bits) - W'(1);
        if (en_t_n) return 1'b1;
        return up ? !((v & mask) == mask) : !((v & mask) == '0);
    endfunction

    // Apply current inputs over one edge, update models, check at negedge.
    task automatic step();
        logic [W-1:0] nq;
        logic [W1-1:0] nq1;
        if (!rst_n) begin
            nq = '0; nq1 = '0;
        end else if (!load_n) begin
            nq = din; nq1 = din[W1-1:0];
        end else if (!en_p_n && !en_t_n) begin
            nq  = up ? mq + 1'b1 : mq - 1'b1;
            nq1 = up ? mq1 + 1'b1 : mq1 - 1'b1;
        end else begin
            nq = mq; nq1 = mq1;
        end
        @(posedge clk);
        mq = nq; mq1 = nq1;
        @(negedge clk);
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en_p_n = 1'b1; en_t_n = 1'b1; load_n = 1'b0;
        up = 1'b1; din = 12'hABC; mq = '0; mq1 = '0;
        @(negedge clk);
        step();
        step();
        check("R1 reset count", 32'(q), 32'h0);
        check("R1 reset single", 32'(q1), 32'h0);
        rst_n = 1'b1;
        load_n = 1'b1;

        for (int i = 0; i < 15; i++) begin
            load_n = TABLE[i].ld_n; en_p_n = TABLE[i].p_n;
            en_t_n = TABLE[i].t_n;  up = TABLE[i].up; din = TABLE[i].din;
            step();
            check($sformatf("R2 R3 R4 R5 row %0d q", i), 32'(q), 32'(TABLE[i].exp_q));
            check($sformatf("R6 row %0d carry", i), 32'(carry_n), 32'(TABLE[i].exp_c));
        end

        // R6: carry follows up and en_t_n between edges.
        load_n = 1'b0; din = 12'hFFF; en_p_n = 1'b1; en_t_n = 1'b1; up = 1'b1;
        step();
        load_n = 1'b1;
        #2;
        check("R6 carry high while T high", 32'(carry_n), 32'h1);
        en_t_n = 1'b0; #2;
        check("R6 carry low on T low", 32'(carry_n), 32'h0);
        up = 1'b0; #2;
        check("R6 carry high on direction flip", 32'(carry_n), 32'h1);

        // R8: reverse exactly at terminal count.
        en_p_n = 1'b0; up = 1'b0;
        step();
        check("R8 reverse at max", 32'(q), 32'hFFE);
        load_n = 1'b0; din = 12'h000; step();
        load_n = 1'b1; up = 1'b0; #2;
        check("R8 carry low at min down", 32'(carry_n), 32'h0);
        up = 1'b1; step();
        check("R8 reverse at min", 32'(q), 32'h001);

        // R5: full wrap of the chain counting up.
        load_n = 1'b0; din = 12'h000; step();
        load_n = 1'b1; en_p_n = 1'b0; en_t_n = 1'b0; up = 1'b1;
        for (int i = 0; i < 4096; i++) step();
        check("R5 full wrap", 32'(q), 32'h000);

        // R7: random stream against the models.
        for (int i = 0; i < 3000; i++) begin
            load_n = ($urandom_range(0, 15) != 0);
            en_p_n = ($urandom_range(0, 5) == 0);
            en_t_n = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 40) == 0) up = ~up;
            if (mq[3:0] == 4'hF || mq[3:0] == 4'h0)
                if ($urandom_range(0, 2) == 0) up = ~up;
            din = 12'($urandom);
            step();
            check("R7 chain q", 32'(q), 32'(mq));
            check("R7 single q", 32'(q1), 32'(mq1));
            check("R7 chain carry", 32'(carry_n), 32'(exp_carry(mq, W)));
            check("R7 single carry", 32'(carry1_n), 32'(exp_carry({8'h0, mq1}, W1)));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule